// File: doc/BRIEF.md
# Interrupt Cause Register Bank

This block gathers up to 32 interrupt sources into one set of seven 32-bit registers on a single-cycle register port. A rising edge on an event input latches the matching cause bit. Software can also force cause bits through a write-only set alias. Each cause bit has its own clearing style, chosen in a control register. A bit in write-one-to-clear style clears when software writes a one to it. A bit in clear-on-read style clears once software has read it as one.

A mask register hides sources from the interrupt line. It can be loaded whole, or individual bits can be set and cleared through two write-only aliases. The single interrupt output is one registered OR of all the unmasked cause bits. Every source sits at the same bit index in all seven registers. A bus read returns data in the same cycle. A write takes effect at the clock edge that ends the access cycle.

Top module: `irq_bank`

## Requirements
- R1: After synchronous reset the cause, control and mask registers are zero, every register reads zero and `irq_o` is low.
- R2: A 0-to-1 transition on `evt_i[i]` sets cause bit i at the next clock edge. An event input that stays high does not set the bit again after it has been cleared.
- R3: When control bit i is 0, writing 1 to bit i at offset 0x04 (cause) or 0x08 (masked cause) clears cause bit i. Writing 0 leaves the bit unchanged. When control bit i is 1, such a write has no effect on bit i.
- R4: When control bit i is 1, a read of offset 0x04 or 0x08 that returns bit i as 1 clears cause bit i on the following cycle. Bits returned as 0 keep their value, and so do bits whose control bit is 0.
- R5: Offset 0x08 reads as the cause bits ANDed with the inverse of the mask, so a mask bit of 1 hides its source.
- R6: Writing 1 to bit i at offset 0x0C sets cause bit i. Offset 0x0C reads as zero.
- R7: Offset 0x10 holds the mask and is written directly. Writing 1 to a bit at 0x14 sets that mask bit, and writing 1 to a bit at 0x18 clears it. Zero bits in those writes change nothing, and both aliases read as zero.
- R8: When an event or a set write hits a cause bit in the same cycle as a write-one or read clear, the bit ends up set.
- R9: `irq_o` equals the OR of the masked cause bits as they stood one cycle earlier.
- R10: Offset 0x00 holds the control register, where 0 selects write-one-to-clear and 1 selects clear-on-read. An address outside 0x00..0x18, or one that is not 4-byte aligned, reads zero and ignores writes.
- R11: The control register reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 32 | Hardware event inputs, edge-detected |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte address within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench sweeps every bit in both clearing styles. A design that ignores the per-bit style would clear a clear-on-read bit on write, or leave it set after a read. The collision cases, where an event meets a write-one clear or a clear-on-read, would lose the event in a design where the clear takes priority. Reading the masked view with a partial mask checks that only the returned bits are cleared. A design that clears from the raw cause would drop a hidden source. The one-cycle lag on `irq_o` is checked on both edges, and so are writes to unmapped and misaligned addresses.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int NUM_REGS = 7;

    typedef enum logic [2:0] {
        RG_CTL    = 3'd0,
        RG_CAUSE  = 3'd1,
        RG_MASKED = 3'd2,
        RG_SET    = 3'd3,
        RG_MVAL   = 3'd4,
        RG_MSET   = 3'd5,
        RG_MCLR   = 3'd6,
        RG_NONE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic ctl_wr;
        logic w1c_wr;
        logic set_wr;
        logic mval_wr;
        logic mset_wr;
        logic mclr_wr;
        logic cause_rd;
        logic masked_rd;
    } bus_strobe_t;

    function automatic logic any_mask_write(bus_strobe_t s);
        return s.mval_wr | s.mset_wr | s.mclr_wr;
    endfunction

endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          rsel,
    output bus_strobe_t       stb
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;

    always_comb begin
        word = addr[ADDR_W-1:2];
        rsel = RG_NONE;
        if (addr[1:0] == 2'b00 && int'(word) < NUM_REGS)
            rsel = reg_sel_e'(word[2:0]);
    end

    always_comb begin
        stb = '0;
        if (sel && wr) begin
            case (rsel)
                RG_CTL:    stb.ctl_wr  = 1'b1;
                RG_CAUSE:  stb.w1c_wr  = 1'b1;
                RG_MASKED: stb.w1c_wr  = 1'b1;
                RG_SET:    stb.set_wr  = 1'b1;
                RG_MVAL:   stb.mval_wr = 1'b1;
                RG_MSET:   stb.mset_wr = 1'b1;
                RG_MCLR:   stb.mclr_wr = 1'b1;
                default:   ;
            endcase
        end else if (sel && !wr) begin
            stb.cause_rd  = (rsel == RG_CAUSE);
            stb.masked_rd = (rsel == RG_MASKED);
        end
    end

endmodule

// File: rtl/irq_bank_mask.sv
module irq_bank_mask
    import irq_bank_pkg::*;
#(
    parameter int N = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_strobe_t stb,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (stb.mval_wr)
            mask_q <= wdata;
        else if (stb.mset_wr)
            mask_q <= mask_q | wdata;
        else if (stb.mclr_wr)
            mask_q <= mask_q & ~wdata;
    end

    // R7: set alias forces ones, clear alias forces zeros, otherwise mask holds
    p_mask_set_r7: assert property (@(posedge clk) disable iff (rst)
        stb.mset_wr |=> ((mask_q & $past(wdata)) == $past(wdata)));
    p_mask_clr_r7: assert property (@(posedge clk) disable iff (rst)
        stb.mclr_wr |=> ((mask_q & $past(wdata)) == '0));
    p_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !any_mask_write(stb) |=> $stable(mask_q));

endmodule

// File: rtl/irq_bank_cause.sv
module irq_bank_cause
    import irq_bank_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt_i,
    input  bus_strobe_t  stb,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] mask,
    output logic [N-1:0] cause_q,
    output logic [N-1:0] ctl_q
);

    logic [N-1:0] evt_d;
    logic [N-1:0] rise;
    logic [N-1:0] set_v;
    logic [N-1:0] w1c_v;
    logic [N-1:0] cor_v;
    logic [N-1:0] clr_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_d <= '0;
            ctl_q <= '0;
        end else begin
            evt_d <= evt_i;
            if (stb.ctl_wr)
                ctl_q <= wdata;
        end
    end

    always_comb begin
        rise  = evt_i & ~evt_d;
        set_v = rise | (stb.set_wr ? wdata : '0);
        w1c_v = stb.w1c_wr ? (wdata & ~ctl_q) : '0;
        if (stb.cause_rd)
            cor_v = cause_q & ctl_q;
        else if (stb.masked_rd)
            cor_v = cause_q & ~mask & ctl_q;
        else
            cor_v = '0;
        clr_v = w1c_v | cor_v;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                cause_q[i] <= 1'b0;
            else if (set_v[i])
                cause_q[i] <= 1'b1;
            else if (clr_v[i])
                cause_q[i] <= 1'b0;
        end
    end

    // R2: an edge on an event input leaves the bit set
    p_edge_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((cause_q & $past(rise)) == $past(rise)));
    // R6 / R8: a forcing write leaves the bits set whatever clear is pending
    p_force_sets_r6: assert property (@(posedge clk) disable iff (rst)
        stb.set_wr |=> ((cause_q & $past(wdata)) == $past(wdata)));
    // R3 / R4: a cause bit only falls when a clear was requested for it
    p_fall_needs_clear_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~cause_q & $past(cause_q) & ~$past(clr_v)) == '0));
    // R3: a write can never clear a bit in clear-on-read style
    p_w1c_spares_cor_r3: assert property (@(posedge clk) disable iff (rst)
        stb.w1c_wr |=> ((~cause_q & $past(cause_q & ctl_q)) == '0));

endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_bank_pkg::*;
#(
    parameter int N      = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      evt_i,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    output logic              irq_o
);

    reg_sel_e     rsel;
    bus_strobe_t  stb;
    logic [N-1:0] cause;
    logic [N-1:0] ctl;
    logic [N-1:0] mask;
    logic [N-1:0] masked;

    irq_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
        .sel  (bus_sel),
        .wr   (bus_wr),
        .addr (bus_addr),
        .rsel (rsel),
        .stb  (stb)
    );

    irq_bank_cause #(.N(N)) u_cause (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt_i),
        .stb     (stb),
        .wdata   (bus_wdata),
        .mask    (mask),
        .cause_q (cause),
        .ctl_q   (ctl)
    );

    irq_bank_mask #(.N(N)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .stb    (stb),
        .wdata  (bus_wdata),
        .mask_q (mask)
    );

    assign masked = cause & ~mask;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (rsel)
                RG_CTL:    bus_rdata = ctl;
                RG_CAUSE:  bus_rdata = cause;
                RG_MASKED: bus_rdata = masked;
                RG_MVAL:   bus_rdata = mask;
                default:   bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_o <= 1'b0;
        else
            irq_o <= |masked;
    end

    // R9: the request line trails the unmasked causes by one cycle
    p_irq_lag_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(|(cause & ~mask))));
    // R10: misaligned accesses read zero
    p_misaligned_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));
    // R11: control register holds unless written
    p_ctl_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_wr && bus_addr == '0) |=> $stable(ctl));

endmodule

// File: tb/irq_bank_tb.sv
`timescale 1ns/1ps
module irq_bank_tb;

    localparam logic [4:0] A_CTL = 5'h00, A_CAUSE = 5'h04, A_MASKED = 5'h08,
                           A_SET = 5'h0C, A_MVAL = 5'h10, A_MSET = 5'h14,
                           A_MCLR = 5'h18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] evt = '0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    irq_bank u_dut (
        .clk(clk), .rst(rst), .evt_i(evt), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(logic [4:0] a, logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic bread(logic [4:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic pulse(logic [31:0] b);
        evt = b;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state on all seven offsets and the request line
        for (int a = 0; a < 7; a++) begin
            bread(5'(a * 4), v);
            chk("R1 reset read", v, 32'h0);
        end
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R11 / R10: low half write-one-to-clear, high half clear-on-read
        bwrite(A_CTL, 32'hFFFF_0000);
        bread(A_CTL, v);
        chk("R11 ctl readback", v, 32'hFFFF_0000);

        // R2 / R3 / R4: per-bit sweep of both clearing styles
        for (int i = 0; i < 32; i++) begin
            pulse(32'h1 << i);
            bread(A_CAUSE, v);
            chk("R2 event latched", v, 32'h1 << i);
            if (i >= 16) begin
                bread(A_CAUSE, v);
                chk("R4 clear on read", v, 32'h0);
            end else begin
                bread(A_CAUSE, v);
                chk("R4 read spares w1c bit", v, 32'h1 << i);
                bwrite(A_CAUSE, 32'h0);
                bread(A_CAUSE, v);
                chk("R3 zero write no effect", v, 32'h1 << i);
                bwrite(A_CAUSE, 32'h1 << i);
                bread(A_CAUSE, v);
                chk("R3 write one clears", v, 32'h0);
            end
        end

        // R2: a held-high input does not set the bit again
        evt = 32'h1;
        @(negedge clk);
        bwrite(A_CAUSE, 32'h1);
        repeat (3) @(negedge clk);
        bread(A_CAUSE, v);
        chk("R2 level does not retrigger", v, 32'h0);
        evt = '0;
        @(negedge clk);

        // R6: forcing write, write-only alias reads zero
        bwrite(A_SET, 32'hA5A5_5A5A);
        bread(A_SET, v);
        chk("R6 set alias reads zero", v, 32'h0);
        bread(A_CAUSE, v);
        chk("R6 forced causes", v, 32'hA5A5_5A5A);
        bread(A_CAUSE, v);
        chk("R4 only cor half cleared", v, 32'h0000_5A5A);
        bwrite(A_MASKED, 32'h0000_5A5A);
        bread(A_CAUSE, v);
        chk("R3 clear via masked offset", v, 32'h0);

        // R7: mask direct write and the two aliases
        bwrite(A_MVAL, 32'h0000_FF00);
        bread(A_MVAL, v);
        chk("R7 mask direct", v, 32'h0000_FF00);
        bwrite(A_MSET, 32'h0F00_0000);
        bread(A_MVAL, v);
        chk("R7 mask set alias", v, 32'h0F00_FF00);
        bwrite(A_MCLR, 32'h0000_0F00);
        bread(A_MVAL, v);
        chk("R7 mask clear alias", v, 32'h0F00_F000);
        bread(A_MSET, v);
        chk("R7 mask set reads zero", v, 32'h0);
        bread(A_MCLR, v);
        chk("R7 mask clear reads zero", v, 32'h0);

        // R5 / R9: masked view and registered request
        bwrite(A_SET, 32'h0000_FFFF);
        chk("R9 irq lags set", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R9 irq rises", {31'b0, irq}, 32'h1);
        bread(A_MASKED, v);
        chk("R5 masked view", v, 32'h0000_0FFF);
        bwrite(A_MVAL, 32'hFFFF_FFFF);
        chk("R9 irq still high one cycle", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R9 irq falls when masked", {31'b0, irq}, 32'h0);
        bread(A_MASKED, v);
        chk("R5 fully masked", v, 32'h0);
        bwrite(A_CAUSE, 32'hFFFF_FFFF);
        bread(A_CAUSE, v);
        chk("R3 w1c clears all low", v, 32'h0);

        // R3: write to a clear-on-read bit has no effect
        bwrite(A_MVAL, 32'h0);
        bwrite(A_SET, 32'h0001_0000);
        bwrite(A_CAUSE, 32'h0001_0000);
        bread(A_CAUSE, v);
        chk("R3 write ignores cor bit", v, 32'h0001_0000);
        bread(A_CAUSE, v);
        chk("R4 cor bit cleared", v, 32'h0);

        // R4 / R5: masked read clears only returned bits
        bwrite(A_MVAL, 32'h0002_0000);
        bwrite(A_SET, 32'h0003_0000);
        bread(A_MASKED, v);
        chk("R5 partial masked read", v, 32'h0001_0000);
        bread(A_CAUSE, v);
        chk("R4 hidden bit kept", v, 32'h0002_0000);
        bwrite(A_MVAL, 32'h0);

        // R8: event meets write-one clear
        bwrite(A_SET, 32'h8);
        evt = 32'h8;
        bwrite(A_CAUSE, 32'h8);
        evt = '0;
        bread(A_CAUSE, v);
        chk("R8 event beats w1c", v, 32'h8);
        bwrite(A_CAUSE, 32'h8);

        // R8: event meets clear-on-read
        bwrite(A_SET, 32'h0010_0000);
        evt = 32'h0010_0000;
        bread(A_CAUSE, v);
        evt = '0;
        chk("R8 read value", v, 32'h0010_0000);
        bread(A_CAUSE, v);
        chk("R8 event beats cor", v, 32'h0010_0000);
        bread(A_CAUSE, v);
        chk("R8 then cleared", v, 32'h0);

        // R10: unmapped and misaligned addresses
        bwrite(5'h1C, 32'hFFFF_FFFF);
        bwrite(5'h0D, 32'hFFFF_FFFF);
        bread(A_CAUSE, v);
        chk("R10 unmapped write ignored cause", v, 32'h0);
        bread(A_MVAL, v);
        chk("R10 unmapped write ignored mask", v, 32'h0);
        bread(A_CTL, v);
        chk("R10 ctl unchanged", v, 32'hFFFF_0000);
        bread(5'h1C, v);
        chk("R10 unmapped reads zero", v, 32'h0);
        bwrite(A_SET, 32'h1);
        bread(5'h05, v);
        chk("R10 misaligned reads zero", v, 32'h0);
        bwrite(A_CAUSE, 32'h1);
        @(negedge clk);
        chk("R9 irq idle at end", {31'b0, irq}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule